// File: doc/BRIEF.md
# Byte/Word Parallel Memory Bus Front End

This block sits behind the pads of a parallel NOR-style memory and turns the asynchronous host bus into internal traffic. It watches three active-low strobes (chip enable, output enable, write enable), a width-select pin, the word address and the sixteen data lanes. It sorts every bus state into read, write or idle. The pad cells are outside the block, so each data lane is presented as an input, an output value and an output enable.

A width-select of 1 selects word mode, with all sixteen lanes in use. A width-select of 0 selects byte mode. Only the low eight lanes then carry data, lanes 14 to 8 float, and lane 15 becomes an input that supplies the lowest address bit, placed below the word address. Reads are combinational: the block forms the internal address, raises a read enable and drives the data returned by the internal read port onto the lanes that are active. Writes are synchronised into the internal clock. When the write window closes, the block delivers one single-cycle strobe carrying the address, the data sized to the width and the width flag.

Top module: `pbus_front`

## Requirements
- R1: With chip enable low, output enable low, write enable high and width-select 1, `dq_oe` is 16'hFFFF and `dq_out` equals `rd_data`.
- R2: With the same strobes and width-select 0, `dq_oe` is 16'h00FF and `dq_out[7:0]` equals `rd_data[7:0]`. Lanes 15 to 8 are not driven.
- R3: In every other combination of chip enable, output enable and write enable, `dq_oe` is 0. This includes the case where all three are low.
- R4: `rd_addr` is `{addr, b}`, where `b` is `dq_in[15]` in byte mode and 0 in word mode. `rd_wide` follows width-select.
- R5: `rd_en` is 1 exactly when chip enable and output enable are low and write enable is high.
- R6: Every bus interval with chip enable and write enable both low is a write, whatever the level of output enable. After the interval ends, it yields one `cmd_valid` pulse carrying the values held during the interval. A read or idle interval yields no pulse.
- R7: A word-mode write gives `cmd_data = dq_in`, `cmd_addr = {addr, 0}` and `cmd_wide = 1`. A byte-mode write gives `cmd_data = {8'h00, dq_in[7:0]}`, so lanes 14 to 8 are ignored. It also gives `cmd_addr = {addr, dq_in[15]}` and `cmd_wide = 0`.
- R8: `cmd_valid` is never high in two consecutive clock cycles.
- R9: During and right after reset, `cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wide | input | 1 | Width select: 1 word, 0 byte |
| addr | input | ADDR_W | Word address from the bus |
| dq_in | input | 16 | Data lanes as seen at the pads |
| dq_out | output | 16 | Values to drive on the lanes |
| dq_oe | output | 16 | Per-lane output enable |
| rd_en | output | 1 | Read access in progress |
| rd_addr | output | ADDR_W+1 | Read address including the low byte bit |
| rd_wide | output | 1 | Width of the read access |
| rd_data | input | 16 | Data from the internal read port |
| cmd_valid | output | 1 | One-cycle write strobe |
| cmd_addr | output | ADDR_W+1 | Write address including the low byte bit |
| cmd_data | output | 16 | Write data sized to the width |
| cmd_wide | output | 1 | Width of the write |

## Verification
The bench holds each of the sixteen combinations of width-select and the three strobes in turn. This tells read lane drive apart from idle tri-state, and tells the word lane mask apart from the byte lane mask. It shows that all-strobes-low counts as a write and is not driven. Byte-mode accesses are repeated with lane 15 at 0 and at 1 at the same word address, and with junk on lanes 14 to 8. This separates correct formation of the low address bit from a lane leak into the upper data. Back-to-back writes in both widths, with distinct data, show that each write gives exactly one strobe carrying its own values.

// File: rtl/pbus_front.sv
module pbus_front #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe,
  output logic              rd_en,
  output logic [ADDR_W:0]   rd_addr,
  output logic              rd_wide,
  input  logic [DATA_W-1:0] rd_data,
  output logic              cmd_valid,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_wide
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}};

  logic              rd_sel, wr_act, lsb;
  logic [ADDR_W:0]   bus_addr;
  logic [DATA_W-1:0] bus_data;

  assign rd_sel   = ~ce_n & ~oe_n & we_n;
  assign wr_act   = ~ce_n & ~we_n;
  assign lsb      = ~wide & dq_in[DATA_W-1];
  assign bus_addr = {addr, lsb};
  assign bus_data = wide ? dq_in : (dq_in & LOW_MASK);

  assign rd_en   = rd_sel;
  assign rd_addr = bus_addr;
  assign rd_wide = wide;
  assign dq_oe   = rd_sel ? (wide ? '1 : LOW_MASK) : '0;
  assign dq_out  = wide ? rd_data : (rd_data & LOW_MASK);

  logic              s1_act, s2_act, s1_wide, s2_wide;
  logic [ADDR_W:0]   s1_addr, s2_addr;
  logic [DATA_W-1:0] s1_data, s2_data;
  logic              done;

  assign done = s2_act & ~s1_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_act    <= 1'b0;
      s2_act    <= 1'b0;
      s1_wide   <= 1'b0;
      s2_wide   <= 1'b0;
      s1_addr   <= '0;
      s2_addr   <= '0;
      s1_data   <= '0;
      s2_data   <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      cmd_wide  <= 1'b0;
    end else begin
      s1_act    <= wr_act;
      s1_wide   <= wide;
      s1_addr   <= bus_addr;
      s1_data   <= bus_data;
      s2_act    <= s1_act;
      s2_wide   <= s1_wide;
      s2_addr   <= s1_addr;
      s2_data   <= s1_data;
      cmd_valid <= done;
      if (done) begin
        cmd_addr <= s2_addr;
        cmd_data <= s2_data;
        cmd_wide <= s2_wide;
      end
    end
  end

  a_r1_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n && wide) |-> (dq_oe == '1 && dq_out == rd_data));

  a_r2_byte_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n && !wide) |-> (dq_oe == LOW_MASK && dq_out[HALF-1:0] == rd_data[HALF-1:0]));

  a_r3_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> (dq_oe == '0 && !rd_en));

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r7_byte_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_wide) |-> (cmd_data[DATA_W-1:HALF] == '0));
endmodule

// File: tb/tb_pbus_front.sv
module tb_pbus_front;
  localparam int AW = 8;
  localparam int EW = AW + 1 + 16 + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wide = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   dq_in = '0;
  logic [15:0]   dq_out, dq_oe, rd_data, cmd_data;
  logic          rd_en, rd_wide, cmd_valid, cmd_wide;
  logic [AW:0]   rd_addr, cmd_addr;

  int checks = 0;
  int fails = 0;
  logic [EW-1:0] expq[$];
  logic prev_valid = 1'b0;

  always #4 clk = ~clk;

  assign rd_data = {~rd_addr[7:0], rd_addr[7:0] ^ 8'h3C};

  pbus_front #(.ADDR_W(AW), .DATA_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .wide(wide),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_wide(rd_wide), .rd_data(rd_data), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_wide(cmd_wide));

  function automatic logic [15:0] model(input logic [AW:0] a);
    return {~a[7:0], a[7:0] ^ 8'h3C};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (prev_valid) check("R8 strobe twice", 32'd1, 32'd0);
      if (expq.size() == 0) check("R6 unexpected strobe", 32'd1, 32'd0);
      else begin
        logic [EW-1:0] e;
        e = expq.pop_front();
        check("R7 cmd_addr", 32'(cmd_addr), 32'(e[EW-1 -: AW+1]));
        check("R7 cmd_data", 32'(cmd_data), 32'(e[16:1]));
        check("R7 cmd_wide", 32'(cmd_wide), 32'(e[0]));
      end
    end
    prev_valid <= cmd_valid;
  end

  task automatic access(input logic w, input logic c, input logic o, input logic wr,
                        input logic [AW-1:0] a, input logic [15:0] d);
    logic rd, isw;
    logic [AW:0] ea;
    logic [15:0] eoe, ed;
    @(negedge clk);
    wide = w; ce_n = c; oe_n = o; we_n = wr; addr = a; dq_in = d;
    rd  = !c && !o && wr;
    isw = !c && !wr;
    ea  = {a, (!w) & d[15]};
    eoe = rd ? (w ? 16'hFFFF : 16'h00FF) : 16'h0000;
    ed  = w ? model(ea) : {8'h00, model(ea) & 16'h00FF};
    if (isw) expq.push_back({ea, (w ? d : {8'h00, d[7:0]}), w});
    #1;
    if (w) check("R1 lane enable", 32'(dq_oe), 32'(eoe));
    else check("R2 lane enable", 32'(dq_oe), 32'(eoe));
    if (!rd) check("R3 idle/write no drive", 32'(dq_oe), 32'(eoe));
    if (rd && w) check("R1 word data", 32'(dq_out), 32'(ed));
    if (rd && !w) check("R2 byte data", 32'(dq_out & 16'h00FF), 32'(ed));
    check("R5 rd_en", 32'(rd_en), 32'(rd));
    check("R4 rd_addr", 32'(rd_addr), 32'(ea));
    check("R4 rd_wide", 32'(rd_wide), 32'(w));
    repeat (4) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 cmd_valid in reset", 32'(cmd_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 cmd_valid after reset", 32'(cmd_valid), 32'd0);
    check("R3 idle after reset", 32'(dq_oe), 32'd0);

    for (int i = 0; i < 16; i++) begin
      logic [15:0] d;
      d = 16'h1234 + 16'(i * 16'h0F1B);
      access(i[3], i[2], i[1], i[0], AW'(8'h10 + i), d);
    end

    access(1'b0, 1'b0, 1'b0, 1'b1, 8'h55, 16'h7F00);
    access(1'b0, 1'b0, 1'b0, 1'b1, 8'h55, 16'hFF00);
    access(1'b1, 1'b0, 1'b0, 1'b1, 8'h55, 16'h8000);
    access(1'b0, 1'b0, 1'b1, 1'b0, 8'hA3, 16'h5AC7);
    access(1'b0, 1'b0, 1'b1, 1'b0, 8'hA3, 16'hA53E);
    access(1'b1, 1'b0, 1'b1, 1'b0, 8'hA3, 16'hBEEF);
    access(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 16'hC0DE);
    access(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'hFFFF);

    repeat (6) @(negedge clk);
    check("R6 all writes delivered", 32'(expq.size()), 32'd0);
    summary();
    $finish;
  end
endmodule